// File: doc/BRIEF.md
# Clock Control Register with Pin Gating

This block is an 8-bit control register for a microcontroller's clock system. It decides what appears on the external system-clock pin in each power mode. It also decides when a newly requested PLL multiplication factor replaces the factor in use. Software writes and reads the register through a simple single-cycle bus. The power-management logic presents the current power mode and a one-cycle strobe. The strobe marks a transition into software standby or subactive operation.

The register has four live fields:
- bit 7: stops the clock output.
- bit 3: selects when a new multiplier takes effect.
- bits 2 to 0: clock-select bits.
- bits 6 to 4: reserved.

A multiplier value is presented on `mult_req` alongside each bus write and is captured into a pending register. It moves to the active output at one of two times, depending on bit 3: on the write itself, or at the next standby strobe. The port direction logic is modelled as a single enable input. The PLL and the clock divider are outside the block.

Top module: `clkctl_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `mult_active` reads 0.
- R2: Hardware standby (`pwr_mode` = 6) has three effects:
  - The pin is high impedance in that cycle: `pin_oe` = 0.
  - At the next clock edge, the register, the pending multiplier and the active multiplier all clear to 0.
  - A write made in that cycle is discarded.
- R3: Software standby (`pwr_mode` = 3) leaves the register contents unchanged.
- R4: Bits 6 to 4 of `rd_data` always read 0, whatever was written to them.
- R5: A write stores bits 7, 3 and 2..0 of `wr_data` at the clock edge. `rd_data` shows them from the next cycle on.
- R6: The clock-running modes are high-speed (0), medium-speed (1), sleep (2) and subactive (7). In these modes, with `pin_oe` = 1:
  - bit 7 = 0: `pin_out` follows `phi_in` combinationally.
  - bit 7 = 1: `pin_out` is 1.
- R7: In the holding modes, `pin_out` is 1 whenever `pin_oe` = 1, whatever bit 7 holds. The holding modes are software standby (3), watch (4) and direct transition (5).
- R8: Outside hardware standby, `pin_oe` equals `port_dir_en`.
- R9: A write with bit 3 = 1 makes `mult_active` equal that write's `mult_req` from the next cycle on.
- R10: A write with bit 3 = 0 captures `mult_req` as pending and leaves `mult_active` unchanged. A later `stby_strobe` copies the pending value to `mult_active`, visible the cycle after the strobe.
- R11: When no write and no strobe occur outside hardware standby, `mult_active` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| mult_req | input | 3 | Requested multiplier, captured on each write |
| rd_data | output | 8 | Register read value |
| pwr_mode | input | 3 | Power mode: 0 high, 1 medium, 2 sleep, 3 sw standby, 4 watch, 5 direct, 6 hw standby, 7 subactive |
| stby_strobe | input | 1 | One-cycle mark of a transition into standby or subactive |
| port_dir_en | input | 1 | Port direction enable for the clock pin |
| phi_in | input | 1 | System clock to be driven on the pin |
| pin_out | output | 1 | Clock pin value |
| pin_oe | output | 1 | Clock pin output enable (0 = high impedance) |
| mult_active | output | 3 | Multiplier factor in use |

## Verification
The pin outputs are combinational in mode, bit 7, `port_dir_en` and `phi_in`. The bench therefore checks them one nanosecond after each input change, inside the low half of the clock, so that no edge intervenes. Register readback, the immediate multiplier update and the hardware-standby clear each land one clock edge after the stimulus. The bench drives those stimuli on a falling edge and samples at the following falling edge. For the deferred multiplier policy, the bench confirms that `mult_active` stays at the old value for several cycles after the write. It then confirms that `mult_active` takes the pending value exactly one edge after the strobe.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int REG_W      = 8;
  localparam int STOP_BIT   = 7;
  localparam int SWMODE_BIT = 3;
  localparam logic [REG_W-1:0] WRITABLE_MASK = 8'h8F;

  typedef enum logic [2:0] {
    PM_HIGH   = 3'd0,
    PM_MED    = 3'd1,
    PM_SLEEP  = 3'd2,
    PM_SWSTBY = 3'd3,
    PM_WATCH  = 3'd4,
    PM_DIRECT = 3'd5,
    PM_HWSTBY = 3'd6,
    PM_SUBACT = 3'd7
  } pwr_mode_e;

  function automatic logic mode_is_hw(input logic [2:0] m);
    return m == PM_HWSTBY;
  endfunction

  function automatic logic mode_holds_high(input logic [2:0] m);
    return (m == PM_SWSTBY) || (m == PM_WATCH) || (m == PM_DIRECT);
  endfunction

  function automatic logic [REG_W-1:0] keep_writable(input logic [REG_W-1:0] d);
    return d & WRITABLE_MASK;
  endfunction

endpackage

// File: rtl/clkctl_regfile.sv
module clkctl_regfile #(
  parameter int W = clkctl_pkg::REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_clear,
  input  logic         wr_accept,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q
);
  import clkctl_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (hw_clear) begin
      ctrl_q <= '0;
    end else if (wr_accept) begin
      ctrl_q <= keep_writable(wr_data);
    end
  end

endmodule

// File: rtl/clkctl_mult.sv
module clkctl_mult #(
  parameter int MW = 3,
  parameter logic [MW-1:0] RESET_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_clear,
  input  logic          load_pending,
  input  logic          load_immediate,
  input  logic          apply_pending,
  input  logic [MW-1:0] req,
  output logic [MW-1:0] pending,
  output logic [MW-1:0] active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= RESET_VAL;
    end else if (hw_clear) begin
      pending <= RESET_VAL;
    end else if (load_pending) begin
      pending <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= RESET_VAL;
    end else if (hw_clear) begin
      active <= RESET_VAL;
    end else if (load_immediate) begin
      active <= req;
    end else if (apply_pending) begin
      active <= pending;
    end
  end

endmodule

// File: rtl/clkctl_pin.sv
module clkctl_pin (
  input  logic [2:0] pwr_mode,
  input  logic       stop_out,
  input  logic       port_dir_en,
  input  logic       phi_in,
  output logic       pin_out,
  output logic       pin_oe
);
  import clkctl_pkg::*;

  logic drive_allowed;
  logic force_high;

  assign drive_allowed = !mode_is_hw(pwr_mode) && port_dir_en;
  assign force_high    = mode_holds_high(pwr_mode) || stop_out;

  always_comb begin
    pin_oe  = drive_allowed;
    pin_out = 1'b0;
    if (drive_allowed) begin
      pin_out = force_high ? 1'b1 : phi_in;
    end
  end

endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg #(
  parameter int MULT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic [MULT_W-1:0] mult_req,
  output logic [7:0]        rd_data,
  input  logic [2:0]        pwr_mode,
  input  logic              stby_strobe,
  input  logic              port_dir_en,
  input  logic              phi_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic [MULT_W-1:0] mult_active
);
  import clkctl_pkg::*;

  logic [REG_W-1:0]  ctrl_q;
  logic [MULT_W-1:0] mult_pending;
  logic              hw_clear;
  logic              wr_accept;
  logic              wr_immediate;
  logic              stby_apply;

  assign hw_clear     = mode_is_hw(pwr_mode);
  assign wr_accept    = wr_en && !hw_clear;
  assign wr_immediate = wr_accept && wr_data[SWMODE_BIT];
  assign stby_apply   = stby_strobe && !hw_clear && !wr_immediate;

  clkctl_regfile #(.W(REG_W)) u_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_clear (hw_clear),
    .wr_accept(wr_accept),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q)
  );

  clkctl_mult #(.MW(MULT_W)) u_mult (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_clear      (hw_clear),
    .load_pending  (wr_accept),
    .load_immediate(wr_immediate),
    .apply_pending (stby_apply),
    .req           (mult_req),
    .pending       (mult_pending),
    .active        (mult_active)
  );

  clkctl_pin u_pin (
    .pwr_mode   (pwr_mode),
    .stop_out   (ctrl_q[STOP_BIT]),
    .port_dir_en(port_dir_en),
    .phi_in     (phi_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

  assign rd_data = ctrl_q;

endmodule

// File: rtl/clkctl_checker.sv
module clkctl_checker #(
  parameter int MULT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [MULT_W-1:0] mult_req,
  input logic [7:0]        rd_data,
  input logic [2:0]        pwr_mode,
  input logic              stby_strobe,
  input logic              port_dir_en,
  input logic              pin_out,
  input logic              pin_oe,
  input logic [MULT_W-1:0] mult_active,
  input logic [MULT_W-1:0] mult_pending,
  input logic              wr_immediate,
  input logic              stby_apply
);

  assert_hw_highz_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd6) |-> !pin_oe);

  assert_hw_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd6) |=> (rd_data == 8'h00 && mult_active == '0));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:4] == 3'b000);

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pwr_mode != 3'd6) |=> (rd_data == ($past(wr_data) & 8'h8F)));

  assert_hold_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && (pwr_mode == 3'd3 || pwr_mode == 3'd4 || pwr_mode == 3'd5)) |-> pin_out);

  assert_oe_follows_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode != 3'd6) |-> (pin_oe == port_dir_en));

  assert_immediate_mult_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_immediate |=> (mult_active == $past(mult_req)));

  assert_deferred_mult_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stby_apply |=> (mult_active == $past(mult_pending)));

  assert_mult_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !stby_strobe && pwr_mode != 3'd6) |=> $stable(mult_active));

endmodule

bind clkctl_reg clkctl_checker #(.MULT_W(MULT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .mult_req    (mult_req),
  .rd_data     (rd_data),
  .pwr_mode    (pwr_mode),
  .stby_strobe (stby_strobe),
  .port_dir_en (port_dir_en),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe),
  .mult_active (mult_active),
  .mult_pending(mult_pending),
  .wr_immediate(wr_immediate),
  .stby_apply  (stby_apply)
);

// File: tb/clkctl_reg_bench.sv
`timescale 1ns/1ps
module clkctl_reg_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] mult_req = 3'd0;
  logic [7:0] rd_data;
  logic [2:0] pwr_mode = 3'd0;
  logic       stby_strobe = 1'b0;
  logic       port_dir_en = 1'b0;
  logic       phi_in = 1'b0;
  logic       pin_out;
  logic       pin_oe;
  logic [2:0] mult_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clkctl_reg u_clkctl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mult_req(mult_req), .rd_data(rd_data), .pwr_mode(pwr_mode),
    .stby_strobe(stby_strobe), .port_dir_en(port_dir_en), .phi_in(phi_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .mult_active(mult_active)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [2:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; mult_req = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    stby_strobe = 1'b1;
    @(negedge clk);
    stby_strobe = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic exp_oe, exp_out;
    logic [2:0] prev;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 mult_active", {5'd0, mult_active}, 8'h00);
    rst_n = 1'b1;

    // R4 and R5: write every byte, read back
    for (int d = 0; d < 256; d++) begin
      wr(d[7:0], 3'd0);
      check("R5 readback", rd_data, d[7:0] & 8'h8F);
      check("R4 reserved", {5'd0, rd_data[6:4]}, 8'h00);
    end

    // R6 R7 R8 R2: pin sweep over modes, stop bit, direction, phi
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 8; m++) begin
        pwr_mode = 3'd0;
        wr(s[0] ? 8'h80 : 8'h00, 3'd0);
        pwr_mode = m[2:0];
        for (int c = 0; c < 4; c++) begin
          port_dir_en = c[1];
          phi_in = c[0];
          #1;
          exp_oe = (m != 6) && c[1];
          check(m == 6 ? "R2 pin_oe" : "R8 pin_oe", {7'd0, pin_oe}, {7'd0, exp_oe});
          if (exp_oe) begin
            if (m >= 3 && m <= 5) exp_out = 1'b1;
            else exp_out = s[0] ? 1'b1 : c[0];
            check((m >= 3 && m <= 5) ? "R7 pin_out" : "R6 pin_out",
                  {7'd0, pin_out}, {7'd0, exp_out});
          end
        end
      end
    end
    pwr_mode = 3'd0;
    port_dir_en = 1'b0;

    // R3: software standby keeps contents
    wr(8'h8B, 3'd2);
    @(negedge clk); pwr_mode = 3'd3;
    repeat (5) @(negedge clk);
    check("R3 retain", rd_data, 8'h8B);
    pwr_mode = 3'd0;

    // R9: immediate policy
    for (int v = 0; v < 8; v++) begin
      wr(8'h08, v[2:0]);
      check("R9 immediate", {5'd0, mult_active}, {5'd0, v[2:0]});
    end

    // R10 R11: deferred policy
    for (int v = 0; v < 8; v++) begin
      prev = mult_active;
      wr(8'h00, 3'(7 - v));
      check("R10 old kept", {5'd0, mult_active}, {5'd0, prev});
      repeat (3) @(negedge clk);
      check("R11 hold", {5'd0, mult_active}, {5'd0, prev});
      strobe();
      check("R10 applied", {5'd0, mult_active}, {5'd0, 3'(7 - v)});
    end

    // R2: hardware standby clears; a write there is discarded
    wr(8'h8F, 3'd5);
    @(negedge clk);
    pwr_mode = 3'd6; wr_en = 1'b1; wr_data = 8'h87; mult_req = 3'd3;
    @(negedge clk);
    wr_en = 1'b0; pwr_mode = 3'd0;
    check("R2 reg clear", rd_data, 8'h00);
    check("R2 mult clear", {5'd0, mult_active}, 8'h00);
    strobe();
    check("R2 pending clear", {5'd0, mult_active}, 8'h00);

    finish_run();
  end

endmodule